// File: doc/BRIEF.md
# 24-hour clock with hourly chime

This block keeps the time of day from one fast system clock. A prescaler turns the system clock into a one-second enable. Three cascaded counters hold seconds, minutes and hours. Each unit leaves the block as a pair of BCD digits, ready for a display driver.

A synchronous clear sets the time to midnight. A run input lets time advance. A minute-set button steps the minute count by one per press, so the clock can be set by hand. While the button is held, the button takes the place of the seconds carry as the source of minute steps.

A chime output goes high on the even seconds from 52 to 58 of minute 59, and again at the first second of each hour. All counting uses clock enables in the single system-clock domain.

Top module: `hms_clock`

## Requirements
- R1: After any cycle with `clr` high, all six digits read 0 and `chime` is high, because 00:00:00 is a chime second.
- R2: The seconds count advances by exactly one for every `TICK_DIV` cycles in which `run` is high. While `run` is low, the prescaler and the seconds count hold their values.
- R3: Seconds count from 0 to 59 and then return to 0. The step from 59 to 0 advances minutes by one, provided `min_adj` is low.
- R4: Minutes count from 0 to 59 and then return to 0. The step from 59 to 0 advances hours by one.
- R5: Hours count from 0 to 23 and then return to 0.
- R6: Each 0-to-1 transition of `min_adj` advances minutes by exactly one, whether `run` is high or low. Holding `min_adj` high gives no further steps.
- R7: While `min_adj` is high, a seconds wrap from 59 to 0 does not advance minutes.
- R8: Each unit is shown as a tens digit in [7:4] and a units digit in [3:0] of the packed pair, both in BCD. For example, 37 appears as tens=3 and units=7.
- R9: `chime` is high exactly when the time reads minute 59 with second 52, 54, 56 or 58, or reads minute 00 with second 00.
- R10: `clr` takes priority over `run` and over `min_adj` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear to 00:00:00 |
| run | input | 1 | Count enable |
| min_adj | input | 1 | Minute-set button; each press steps minutes by one |
| hr_tens | output | 4 | Hours, tens digit (BCD) |
| hr_ones | output | 4 | Hours, units digit (BCD) |
| min_tens | output | 4 | Minutes, tens digit (BCD) |
| min_ones | output | 4 | Minutes, units digit (BCD) |
| sec_tens | output | 4 | Seconds, tens digit (BCD) |
| sec_ones | output | 4 | Seconds, units digit (BCD) |
| chime | output | 1 | Hourly chime |

## Verification
The bench builds the block with `TICK_DIV` set to 3, so one simulated second lasts three system clocks. This makes full seconds and minute wraps cheap. Hour and day rollover come within reach by stepping minutes with 1439 button presses and then running the last 20 seconds of 23:59. That path covers every chime second and the 23:59:59 to 00:00:00 wrap. A long random phase then mixes clear, run and button activity against a bench model of the requirements.

// File: rtl/hms_clock.sv
module hms_clock #(
  parameter int unsigned TICK_DIV = 20_000_000
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       run,
  input  logic       min_adj,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic       chime
);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;
  logic [5:0]    sec_q, min_q;
  logic [4:0]    hr_q;
  logic          adj_q;

  logic tick, adj_pulse, sec_wrap, min_step, min_wrap;
  assign tick      = run && (div_q == DIV_LAST);
  assign adj_pulse = min_adj && !adj_q;
  assign sec_wrap  = tick && (sec_q == 6'd59);
  assign min_step  = min_adj ? adj_pulse : sec_wrap;
  assign min_wrap  = min_step && (min_q == 6'd59);

  always_ff @(posedge clk) begin
    if (clr) begin
      div_q <= '0;
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      adj_q <= 1'b0;
    end else begin
      adj_q <= min_adj;
      if (run)      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick)     sec_q <= sec_wrap ? 6'd0 : sec_q + 6'd1;
      if (min_step) min_q <= min_wrap ? 6'd0 : min_q + 6'd1;
      if (min_wrap) hr_q  <= (hr_q == 5'd23) ? 5'd0 : hr_q + 5'd1;
    end
  end

  function automatic logic [7:0] to_bcd(input logic [5:0] v);
    return {4'(v / 6'd10), 4'(v % 6'd10)};
  endfunction

  assign {hr_tens, hr_ones}   = to_bcd({1'b0, hr_q});
  assign {min_tens, min_ones} = to_bcd(min_q);
  assign {sec_tens, sec_ones} = to_bcd(sec_q);

  assign chime = ((min_q == 6'd59) && (sec_q >= 6'd52) && !sec_q[0])
               || ((min_q == 6'd0) && (sec_q == 6'd0));
endmodule

// File: rtl/hms_clock_chk.sv
module hms_clock_chk (
  input logic       clk,
  input logic       clr,
  input logic       run,
  input logic       min_adj,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones,
  input logic       chime
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  logic [7:0] mm, ss;
  assign mm = {min_tens, min_ones};
  assign ss = {sec_tens, sec_ones};

  assert_clear_R1: assert property (@(posedge clk)
    clr |=> ({hr_tens, hr_ones, mm, ss} == 24'h0 && chime));

  assert_hold_R2: assert property (@(posedge clk) disable iff (clr || !armed)
    !run |=> $stable(ss));

  assert_sec_range_R3: assert property (@(posedge clk) disable iff (clr || !armed)
    sec_tens < 4'd6 && sec_ones < 4'd10);

  assert_min_range_R4: assert property (@(posedge clk) disable iff (clr || !armed)
    min_tens < 4'd6 && min_ones < 4'd10);

  assert_hour_range_R5: assert property (@(posedge clk) disable iff (clr || !armed)
    {hr_tens, hr_ones} <= 8'h23 && hr_ones < 4'd10);

  assert_adj_step_R6: assert property (@(posedge clk) disable iff (clr || !armed)
    $rose(min_adj) |=> (mm != $past(mm)));

  assert_adj_held_R7: assert property (@(posedge clk) disable iff (clr || !armed)
    (min_adj && $past(min_adj) && !$past(clr)) |=> $stable(mm));

  assert_chime_R9: assert property (@(posedge clk) disable iff (clr || !armed)
    chime |-> ((mm == 8'h59 && sec_tens == 4'd5 && sec_ones >= 4'd2 && !sec_ones[0] && sec_ones != 4'd0)
              || (mm == 8'h00 && ss == 8'h00)));
endmodule

bind hms_clock hms_clock_chk u_chk (
  .clk(clk), .clr(clr), .run(run), .min_adj(min_adj),
  .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens), .min_ones(min_ones),
  .sec_tens(sec_tens), .sec_ones(sec_ones), .chime(chime)
);

// File: tb/tb_hms_clock.sv
module tb_hms_clock;
  localparam int D = 3;

  logic clk = 1'b0;
  logic clr, run, min_adj;
  logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;
  logic chime;

  always #10 clk = ~clk;

  hms_clock #(.TICK_DIV(D)) dut (
    .clk(clk), .clr(clr), .run(run), .min_adj(min_adj),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .sec_ones(sec_ones), .chime(chime)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_div = 0, m_s = 0, m_m = 0, m_h = 0;
  bit m_aq = 0;

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic bit exp_chime(input int m, input int s);
    return (m == 59 && (s == 52 || s == 54 || s == 56 || s == 58)) || (m == 0 && s == 0);
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int hh, mm, ss;
    hh = {hr_tens, hr_ones}; mm = {min_tens, min_ones}; ss = {sec_tens, sec_ones};
    check(hh == bcd(m_h), tag, "hours", hh, bcd(m_h));
    check(mm == bcd(m_m), tag, "minutes", mm, bcd(m_m));
    check(ss == bcd(m_s), tag, "seconds", ss, bcd(m_s));
    check(chime == exp_chime(m_m, m_s), tag, "chime", chime, exp_chime(m_m, m_s));
  endtask

  task automatic step(input bit c, input bit r, input bit a, input string tag);
    bit pulse, tk, swrap, mstep, mwrap;
    clr = c; run = r; min_adj = a;
    @(posedge clk);
    if (c) begin
      m_div = 0; m_s = 0; m_m = 0; m_h = 0; m_aq = 0;
    end else begin
      pulse = a && !m_aq;
      m_aq = a;
      tk = r && (m_div == D - 1);
      if (r) m_div = tk ? 0 : m_div + 1;
      swrap = tk && (m_s == 59);
      if (tk) m_s = swrap ? 0 : m_s + 1;
      mstep = a ? pulse : swrap;
      mwrap = mstep && (m_m == 59);
      if (mstep) m_m = mwrap ? 0 : m_m + 1;
      if (mwrap) m_h = (m_h == 23) ? 0 : m_h + 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clr = 1'b1; run = 1'b0; min_adj = 1'b0;
    @(negedge clk);
    // R1: clear gives midnight with chime
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R1");
    // R3: run through a full minute into the next
    for (int i = 0; i < 200; i++) step(0, 1, 0, "R3");
    // R2: hold with run low
    for (int i = 0; i < 20; i++) step(0, 0, 0, "R2");
    // R6: held presses give a single step each
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 10; i++) step(0, p[0], 1, "R6");
      for (int i = 0; i < 2; i++) step(0, 0, 0, "R6");
    end
    // R7: seconds wrap while the button is held
    for (int i = 0; i < 200; i++) step(0, 1, 1, "R7");
    // R10: clear wins over run and adjust
    for (int i = 0; i < 2; i++) step(1, 1, 1, "R10");
    step(0, 0, 0, "R10");
    // R4: minute wraps carry hours, driven by presses up to 23:59
    for (int i = 0; i < 1439; i++) begin
      step(0, 0, 1, "R4");
      step(0, 0, 0, "R4");
    end
    // R8: BCD digits while running to 23:59:40
    for (int i = 0; i < 40 * D; i++) step(0, 1, 0, "R8");
    // R9: chime seconds, then day rollover
    for (int i = 0; i < 20 * D; i++) step(0, 1, 0, "R9");
    check({hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones} == 24'h0, "R5", "day rollover",
          {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones}, 0);
    check(chime == 1'b1, "R9", "chime at hour", chime, 1);
    for (int i = 0; i < 2 * D; i++) step(0, 1, 0, "R9");
    check(chime == 1'b0, "R9", "chime after hour", chime, 0);
    // R2: random mix
    for (int i = 0; i < 20000; i++)
      step(($urandom % 500) == 0, ($urandom % 10) < 7, ($urandom % 20) == 0, "R2");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule